// File: doc/BRIEF.md
# Resolver Angle and Velocity Sampler

This block sits on the host side of a resolver-to-digital converter and performs one measurement per request. For an angle or speed reading it pulls the converter's active-low hold strobe low, waits a guard time measured in converter clock periods, drives the two mode-select pins for the requested quantity and then clocks a 16-bit word out of the converter over a four-wire serial link. The serial link idles with the clock high, and data is captured on the rising clock edge. The word arrives most significant bit first.

The block aligns the word to the resolution set on its static inputs (10, 12, 14 or 16 bits) and presents it as a 16-bit result with a one-cycle strobe and a flag that marks speed readings. Speed words are always aligned and sign-extended. Angle words are aligned only when hysteresis is enabled.

A third request kind clears latched faults. It gives the hold strobe a first low pulse and then returns it high. It then reads the fault register over the serial link with the mode pins in configuration position, and gives the strobe a second low pulse and returns it high. The fault byte is reported with its own strobe. Guard times are counted in system clocks from parameters that give the converter clock period and a fixed margin.

Top module: `rsv_sampler`

## Requirements
- R1: After reset, `sample_n`, `spi_cs_n` and `spi_sclk` are high, the mode pins read `mode_a1`=0 and `mode_a0`=1 (configuration position), and `busy`, `result_valid` and `fault_valid` are low.
- R2: A request is taken when `req_valid` is high and the block is idle. `req_kind` 0 starts an angle reading, 1 starts a speed reading and 2 starts a fault clear.
- R3: A request with `req_kind` 3 is ignored. `busy` stays low and `sample_n` does not fall.
- R4: A request that arrives while `busy` is high is ignored. The running operation completes unchanged and no further operation starts.
- R5: In a reading, `sample_n` falls first and stays low for at least 6·CLKIN_CYC+EXTRA_CYC cycles before `spi_cs_n` falls. The mode pins are set when the transfer starts ({a1,a0} = 00 for angle, 10 for speed), stay stable for the whole transfer, and `sample_n` stays low until the transfer ends.
- R6: A transfer is 16 clock pulses. The clock idles high. MOSI changes on the falling edge and MISO is sampled on the rising edge, most significant bit first, so the first received byte is the upper byte of the word.
- R7: Angle result: the received word shifted right by 16 − resolution when `hyst_en` is 1, and the unshifted word when it is 0. `res_code` 0, 1, 2 and 3 select resolutions of 10, 12, 14 and 16 bits.
- R8: Speed result: the received word treated as signed and arithmetically shifted right by 16 − resolution, whatever `hyst_en` is, so that every bit above the resolution copies the sign.
- R9: After a reading, `sample_n` returns high, and `result_valid` pulses for one cycle no sooner than 2·CLKIN_CYC+EXTRA_CYC cycles later. During that pulse `busy` is low, and `result_is_vel` is 1 for a speed reading and 0 for an angle reading.
- R10: Fault clear: `sample_n` is pulsed low and then held high. A 16-bit transfer follows with mode pins {a1,a0}=01, sending 0xFFFF (fault register address with the read flag, then a filler byte). `fault_code` takes the second received byte. `sample_n` is pulsed low once more and returned high, and then `fault_valid` pulses for one cycle.
- R11: A request presented in the cycle in which `result_valid` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 angle, 1 speed, 2 fault clear, 3 ignored |
| res_code | input | 2 | Resolution select: 10/12/14/16 bits |
| hyst_en | input | 1 | Hysteresis enabled; governs angle alignment |
| busy | output | 1 | Operation in progress |
| sample_n | output | 1 | Active-low hold strobe to the converter |
| mode_a0 | output | 1 | Mode select, low pin |
| mode_a1 | output | 1 | Mode select, high pin |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_cs_n | output | 1 | Serial chip select, active low |
| spi_mosi | output | 1 | Serial data to converter |
| spi_miso | input | 1 | Serial data from converter |
| result | output | 16 | Aligned reading |
| result_valid | output | 1 | One-cycle strobe for `result` |
| result_is_vel | output | 1 | Reading was a speed reading |
| fault_code | output | 8 | Fault byte from the last clear |
| fault_valid | output | 1 | One-cycle strobe for `fault_code` |

## Verification
Two things can fall on the same clock edge: completion of one reading and acceptance of the next request. The bench provokes this by raising a speed request in the very cycle it sees the angle strobe. It then requires `busy` to rise on the following edge and a correctly signed speed result to follow. A request raised in the middle of a reading is the contrasting case. It must leave the ongoing angle result, the flag and the number of hold-strobe pulses unchanged, and afterwards the block must stay idle.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    localparam int DATA_W   = 16;
    localparam int RES_MIN  = 10;
    localparam int RES_STEP = 2;

    localparam logic [7:0] FAULT_REG_ADDR = 8'hFF;
    localparam logic [7:0] RD_FLAG        = 8'h80;

    typedef enum logic [1:0] {
        REQ_POS  = 2'd0,
        REQ_VEL  = 2'd1,
        REQ_FCLR = 2'd2,
        REQ_RSVD = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HOLD,
        ST_MXFER,
        ST_TAIL,
        ST_FLO1,
        ST_FXFER,
        ST_FLO2,
        ST_FTAIL
    } seq_state_e;

    typedef struct packed {
        logic a1;
        logic a0;
    } mode_pins_t;

    // Pin pattern for each operation; anything but a reading uses config position.
    function automatic mode_pins_t pins_for(req_kind_e k);
        case (k)
            REQ_POS: return mode_pins_t'{a1: 1'b0, a0: 1'b0};
            REQ_VEL: return mode_pins_t'{a1: 1'b1, a0: 1'b0};
            default: return mode_pins_t'{a1: 1'b0, a0: 1'b1};
        endcase
    endfunction

    // Word sent during a fault-register read: address with read flag, filler.
    function automatic logic [DATA_W-1:0] fault_read_word();
        return {FAULT_REG_ADDR | RD_FLAG, FAULT_REG_ADDR};
    endfunction

endpackage

// File: rtl/rsv_guard_timer.sv
module rsv_guard_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rsv_spi_mode3.sv
module rsv_spi_mode3 #(
    parameter int WIDTH = 16,
    parameter int HALF  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WIDTH-1:0] tx_word,
    output logic [WIDTH-1:0] rx_word,
    output logic             done,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    localparam int EDGES = 2 * WIDTH;
    localparam int EC_W  = $clog2(EDGES + 1);
    localparam int HC_W  = $clog2(HALF + 1);

    logic             active_q;
    logic [HC_W-1:0]  hc_q;
    logic [EC_W-1:0]  ec_q;
    logic [WIDTH-1:0] tx_q;
    logic [WIDTH-1:0] rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            hc_q     <= '0;
            ec_q     <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            sclk     <= 1'b1;
            cs_n     <= 1'b1;
            mosi     <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!active_q) begin
                if (start) begin
                    active_q <= 1'b1;
                    cs_n     <= 1'b0;
                    tx_q     <= tx_word;
                    hc_q     <= HC_W'(HALF - 1);
                    ec_q     <= '0;
                end
            end else if (hc_q != '0) begin
                hc_q <= hc_q - 1'b1;
            end else begin
                hc_q <= HC_W'(HALF - 1);
                if (ec_q == EC_W'(EDGES)) begin
                    cs_n     <= 1'b1;
                    active_q <= 1'b0;
                    done     <= 1'b1;
                end else if (!ec_q[0]) begin
                    // leading (falling) edge: present next bit
                    sclk <= 1'b0;
                    mosi <= tx_q[WIDTH-1];
                    tx_q <= {tx_q[WIDTH-2:0], 1'b0};
                    ec_q <= ec_q + 1'b1;
                end else begin
                    // trailing (rising) edge: capture
                    sclk <= 1'b1;
                    rx_q <= {rx_q[WIDTH-2:0], miso};
                    ec_q <= ec_q + 1'b1;
                end
            end
        end
    end

    assign rx_word = rx_q;
endmodule

// File: rtl/rsv_result_fmt.sv
module rsv_result_fmt
    import rsv_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] raw,
    input  logic [1:0]   res_code,
    input  logic         hyst_en,
    input  logic         is_vel,
    output logic [W-1:0] scaled
);
    localparam int SH_W = $clog2(W);

    logic [SH_W-1:0] shamt;
    logic [W-1:0]    pos_v;
    logic [W-1:0]    vel_v;

    always_comb begin
        shamt  = SH_W'(W - (RES_MIN + RES_STEP * int'(res_code)));
        pos_v  = hyst_en ? (raw >> shamt) : raw;
        vel_v  = W'($signed(raw) >>> shamt);
        scaled = is_vel ? vel_v : pos_v;
    end
endmodule

// File: rtl/rsv_sampler.sv
module rsv_sampler
    import rsv_pkg::*;
#(
    parameter int CLKIN_CYC = 16,
    parameter int EXTRA_CYC = 3,
    parameter int SCLK_HALF = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        res_code,
    input  logic              hyst_en,
    output logic              busy,
    output logic              sample_n,
    output logic              mode_a0,
    output logic              mode_a1,
    output logic              spi_sclk,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              result_is_vel,
    output logic [7:0]        fault_code,
    output logic              fault_valid
);
    localparam int LONG_CYC  = 6 * CLKIN_CYC + EXTRA_CYC;
    localparam int SHORT_CYC = 2 * CLKIN_CYC + EXTRA_CYC;
    localparam int TMR_W     = $clog2(LONG_CYC + 1);

    seq_state_e        state_q;
    req_kind_e         kind_q;
    mode_pins_t        pins_q;
    logic              samp_q;
    logic [DATA_W-1:0] result_q;
    logic              rvalid_q;
    logic              isvel_q;
    logic [7:0]        fault_q;
    logic              fvalid_q;

    logic              accept;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              tmr_exp;
    logic              spi_start;
    logic              spi_done;
    logic [DATA_W-1:0] spi_rx;
    logic [DATA_W-1:0] spi_tx;
    logic [DATA_W-1:0] fmt_out;

    assign accept = (state_q == ST_IDLE) && req_valid && (req_kind_e'(req_kind) != REQ_RSVD);
    assign spi_tx = (kind_q == REQ_FCLR) ? fault_read_word() : '0;

    always_comb begin
        tmr_load  = 1'b0;
        tmr_val   = TMR_W'(SHORT_CYC);
        spi_start = 1'b0;
        case (state_q)
            ST_IDLE: if (accept) begin
                tmr_load = 1'b1;
                if (req_kind_e'(req_kind) != REQ_FCLR)
                    tmr_val = TMR_W'(LONG_CYC);
            end
            ST_HOLD:  spi_start = tmr_exp;
            ST_FLO1:  spi_start = tmr_exp;
            ST_MXFER: tmr_load  = spi_done;
            ST_FXFER: tmr_load  = spi_done;
            ST_FLO2:  tmr_load  = tmr_exp;
            default: ;
        endcase
    end

    rsv_guard_timer #(.CNT_W(TMR_W)) tmr_i (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(tmr_exp)
    );

    rsv_spi_mode3 #(.WIDTH(DATA_W), .HALF(SCLK_HALF)) spi_i (
        .clk(clk), .rst(rst), .start(spi_start), .tx_word(spi_tx),
        .rx_word(spi_rx), .done(spi_done), .sclk(spi_sclk), .cs_n(spi_cs_n),
        .mosi(spi_mosi), .miso(spi_miso)
    );

    rsv_result_fmt #(.W(DATA_W)) fmt_i (
        .raw(spi_rx), .res_code(res_code), .hyst_en(hyst_en),
        .is_vel(kind_q == REQ_VEL), .scaled(fmt_out)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            kind_q   <= REQ_POS;
            pins_q   <= pins_for(REQ_FCLR);
            samp_q   <= 1'b1;
            result_q <= '0;
            rvalid_q <= 1'b0;
            isvel_q  <= 1'b0;
            fault_q  <= '0;
            fvalid_q <= 1'b0;
        end else begin
            rvalid_q <= 1'b0;
            fvalid_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (accept) begin
                    kind_q  <= req_kind_e'(req_kind);
                    samp_q  <= 1'b0;
                    state_q <= (req_kind_e'(req_kind) == REQ_FCLR) ? ST_FLO1 : ST_HOLD;
                end
                ST_HOLD: if (tmr_exp) begin
                    pins_q  <= pins_for(kind_q);
                    state_q <= ST_MXFER;
                end
                ST_MXFER: if (spi_done) begin
                    result_q <= fmt_out;
                    samp_q   <= 1'b1;
                    state_q  <= ST_TAIL;
                end
                ST_TAIL: if (tmr_exp) begin
                    rvalid_q <= 1'b1;
                    isvel_q  <= (kind_q == REQ_VEL);
                    state_q  <= ST_IDLE;
                end
                ST_FLO1: if (tmr_exp) begin
                    samp_q  <= 1'b1;
                    pins_q  <= pins_for(REQ_FCLR);
                    state_q <= ST_FXFER;
                end
                ST_FXFER: if (spi_done) begin
                    fault_q <= spi_rx[7:0];
                    samp_q  <= 1'b0;
                    state_q <= ST_FLO2;
                end
                ST_FLO2: if (tmr_exp) begin
                    samp_q  <= 1'b1;
                    state_q <= ST_FTAIL;
                end
                ST_FTAIL: if (tmr_exp) begin
                    fvalid_q <= 1'b1;
                    state_q  <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy          = (state_q != ST_IDLE);
    assign sample_n      = samp_q;
    assign mode_a0       = pins_q.a0;
    assign mode_a1       = pins_q.a1;
    assign result        = result_q;
    assign result_valid  = rvalid_q;
    assign result_is_vel = isvel_q;
    assign fault_code    = fault_q;
    assign fault_valid   = fvalid_q;
endmodule

// File: rtl/rsv_sampler_chk.sv
module rsv_sampler_chk #(
    parameter int CLKIN_CYC = 16,
    parameter int EXTRA_CYC = 3
) (
    input logic clk,
    input logic rst,
    input logic sample_n,
    input logic mode_a0,
    input logic mode_a1,
    input logic spi_cs_n,
    input logic spi_sclk,
    input logic busy,
    input logic result_valid,
    input logic fault_valid
);
    localparam int HOLD_MIN = 6 * CLKIN_CYC + EXTRA_CYC;
    localparam int LC_W     = $clog2(HOLD_MIN + 2);

    logic [LC_W-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || sample_n)
            low_cnt <= '0;
        else if (low_cnt != LC_W'(HOLD_MIN + 1))
            low_cnt <= low_cnt + 1'b1;
    end

    // R6
    sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> spi_sclk);

    // R5
    meas_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(spi_cs_n) && !mode_a0) |-> (!sample_n && (int'(low_cnt) >= HOLD_MIN)));

    // R5
    mode_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && $past(!spi_cs_n)) |-> $stable({mode_a1, mode_a0}));

    // R10
    fclr_read_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(spi_cs_n) && mode_a0) |-> (sample_n && !mode_a1));

    // R9
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R9
    valid_release_chk: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (sample_n && !busy));

    // R10
    fvalid_release_chk: assert property (@(posedge clk) disable iff (rst)
        fault_valid |-> (sample_n && !busy && !result_valid));
endmodule

bind rsv_sampler rsv_sampler_chk #(.CLKIN_CYC(CLKIN_CYC), .EXTRA_CYC(EXTRA_CYC)) chk_i (
    .clk(clk), .rst(rst), .sample_n(sample_n), .mode_a0(mode_a0), .mode_a1(mode_a1),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .busy(busy),
    .result_valid(result_valid), .fault_valid(fault_valid)
);

// File: tb/rsv_sampler_tb_top.sv
module rsv_sampler_tb_top;
    localparam int CLKIN = 16;
    localparam int EXTRA = 3;
    localparam int LONG  = 6 * CLKIN + EXTRA;
    localparam int SHORT = 2 * CLKIN + EXTRA;
    localparam int NV    = 10;

    // {kind[36:35], res[34:33], hyst[32], slave word[31:16], expected[15:0]}
    localparam logic [36:0] VEC [NV] = '{
        {2'd0, 2'd0, 1'b1, 16'hABCD, 16'h02AF},
        {2'd0, 2'd3, 1'b1, 16'h1234, 16'h1234},
        {2'd0, 2'd1, 1'b0, 16'hF00F, 16'hF00F},
        {2'd0, 2'd2, 1'b1, 16'hFFFF, 16'h3FFF},
        {2'd1, 2'd1, 1'b1, 16'h8010, 16'hF801},
        {2'd1, 2'd0, 1'b0, 16'h7FC0, 16'h01FF},
        {2'd1, 2'd2, 1'b1, 16'hFFFC, 16'hFFFF},
        {2'd1, 2'd3, 1'b0, 16'h8000, 16'h8000},
        {2'd1, 2'd0, 1'b1, 16'hC03F, 16'hFF00},
        {2'd0, 2'd0, 1'b0, 16'h0040, 16'h0040}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [1:0] res_code = 2'd0;
    logic hyst_en = 1'b0;
    logic spi_miso = 1'b0;
    logic busy, sample_n, mode_a0, mode_a1, spi_sclk, spi_cs_n, spi_mosi;
    logic [15:0] result;
    logic result_valid, result_is_vel, fault_valid;
    logic [7:0] fault_code;

    int n_chk = 0;
    int n_fail = 0;

    logic [15:0] slave_word = 16'h0;
    logic [15:0] slave_sh;
    logic [15:0] mosi_cap;
    int          bits;
    int          low_cnt, high_cnt, hold_len, tail_len, sfall;
    logic [1:0]  cs_mode;
    logic        cs_samp;

    rsv_sampler #(.CLKIN_CYC(CLKIN), .EXTRA_CYC(EXTRA), .SCLK_HALF(4)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .res_code(res_code), .hyst_en(hyst_en), .busy(busy), .sample_n(sample_n),
        .mode_a0(mode_a0), .mode_a1(mode_a1), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .result(result),
        .result_valid(result_valid), .result_is_vel(result_is_vel),
        .fault_code(fault_code), .fault_valid(fault_valid)
    );

    initial forever #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // converter model: bit presented on falling clock, word loaded at select
    initial forever begin
        @(negedge spi_cs_n);
        slave_sh = slave_word;
        mosi_cap = '0;
        bits = 0;
    end
    initial forever begin
        @(negedge spi_sclk);
        spi_miso = slave_sh[15];
        slave_sh = {slave_sh[14:0], 1'b0};
    end
    initial forever begin
        @(posedge spi_sclk);
        if (!spi_cs_n) begin
            mosi_cap = {mosi_cap[14:0], spi_mosi};
            bits++;
        end
    end

    // pin timing monitor, sampled away from the active edge
    initial begin
        logic prev_s, prev_cs;
        prev_s = 1'b1; prev_cs = 1'b1;
        low_cnt = 0; high_cnt = 0; hold_len = 0; tail_len = 0; sfall = 0;
        forever begin
            @(negedge clk);
            if (prev_s && !sample_n) begin low_cnt = 1; sfall++; end
            else if (!sample_n) low_cnt++;
            if (!prev_s && sample_n) high_cnt = 1;
            else if (sample_n) high_cnt++;
            if (prev_cs && !spi_cs_n) begin
                hold_len = low_cnt;
                cs_mode  = {mode_a1, mode_a0};
                cs_samp  = sample_n;
            end
            if (result_valid) tail_len = high_cnt;
            prev_s = sample_n; prev_cs = spi_cs_n;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    task automatic do_req(input logic [1:0] k);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_result();
        do @(negedge clk); while (!result_valid);
    endtask

    task automatic wait_fault();
        do @(negedge clk); while (!fault_valid);
    endtask

    initial begin
        int s0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 sample_n", sample_n, 1);
        chk("R1 cs_n/sclk", {spi_cs_n, spi_sclk}, 2'b11);
        chk("R1 mode pins", {mode_a1, mode_a0}, 2'b01);
        chk("R1 busy/strobes", {busy, result_valid, fault_valid}, 3'b000);

        // R2 R5 R7 R8 R9: table of readings
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            res_code   = VEC[i][34:33];
            hyst_en    = VEC[i][32];
            slave_word = VEC[i][31:16];
            do_req(VEC[i][36:35]);
            wait_result();
            @(negedge clk);
            if (VEC[i][36:35] == 2'd1) begin
                chk($sformatf("R8 speed result vec%0d", i), result, VEC[i][15:0]);
                chk($sformatf("R5 speed mode pins vec%0d", i), cs_mode, 2'b10);
                chk($sformatf("R9 speed flag vec%0d", i), result_is_vel, 1);
            end else begin
                chk($sformatf("R7 angle result vec%0d", i), result, VEC[i][15:0]);
                chk($sformatf("R5 angle mode pins vec%0d", i), cs_mode, 2'b00);
                chk($sformatf("R9 angle flag vec%0d", i), result_is_vel, 0);
            end
            chk($sformatf("R5 strobe low at select vec%0d", i), cs_samp, 0);
            chk($sformatf("R5 hold time vec%0d", i), hold_len >= LONG + 1, 1);
            chk($sformatf("R9 tail time vec%0d", i), tail_len >= SHORT + 1, 1);
            chk($sformatf("R6 clock count vec%0d", i), bits, 16);
        end

        // R10 fault clear
        slave_word = 16'h3CA5;
        s0 = sfall;
        do_req(2'd2);
        wait_fault();
        @(negedge clk);
        chk("R10 fault byte", fault_code, 8'hA5);
        chk("R10 address sent", mosi_cap, 16'hFFFF);
        chk("R10 mode pins", cs_mode, 2'b01);
        chk("R10 strobe high during read", cs_samp, 1);
        chk("R10 two strobe pulses", sfall - s0, 2);
        chk("R10 strobe released", sample_n, 1);

        // R3 reserved kind ignored
        s0 = sfall;
        do_req(2'd3);
        repeat (5) @(negedge clk);
        chk("R3 busy", busy, 0);
        chk("R3 no strobe", sfall - s0, 0);

        // R4 request while busy
        res_code = 2'd3; hyst_en = 1'b1; slave_word = 16'h5678;
        s0 = sfall;
        do_req(2'd0);
        repeat (20) @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_result();
        @(negedge clk);
        chk("R4 result unchanged", result, 16'h5678);
        chk("R4 flag unchanged", result_is_vel, 0);
        repeat (10) @(negedge clk);
        chk("R4 stays idle", {busy, sample_n}, 2'b01);
        chk("R4 single strobe", sfall - s0, 1);

        // R11 request in the strobe cycle
        slave_word = 16'h9000; res_code = 2'd1; hyst_en = 1'b0;
        do_req(2'd0);
        wait_result();
        req_valid = 1'b1; req_kind = 2'd1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 accepted on strobe", busy, 1);
        wait_result();
        @(negedge clk);
        chk("R11 speed result", result, 16'hF900);
        chk("R11 speed flag", result_is_vel, 1);

        summary();
    end
endmodule